// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished conversion results from an analog-to-digital converter. It compares each one against two programmable thresholds: a lower bound the result must exceed (the "above" threshold) and an upper bound the result must stay under (the "below" threshold). It does this on every accepted result, with no processor action. When a result meets the window condition, the block sets a sticky window flag. Software can poll that flag, or it can route the flag to a dedicated interrupt line through an enable bit of its own. This line is separate from any conversion-complete interrupt.

No mode bit selects the kind of window. The ordering of the two thresholds selects it. When the "below" threshold is larger than the "above" threshold, the flag marks results strictly inside the band. When it is smaller or equal, the flag marks results strictly outside the band. A result-format input chooses between unsigned codes (single-ended) and two's-complement codes (differential). The register bus is reduced to plain write strobes with data.

Results arrive on a valid/ready stream. The block never applies back-pressure. `res_ready` is low while reset is asserted, goes high on the first clock edge after reset is released, and then stays high. A result is consumed on every cycle in which `res_valid` and `res_ready` are both high. `res_signed` is sampled together with the result.

Top module: `adc_win_cmp`

## Requirements
- R1: After reset, `win_flag`, `win_irq` and the interrupt enable are 0, and both thresholds are 0.
- R2: When the "below" threshold is greater than the "above" threshold (inside mode), an accepted result sets the flag only if it is strictly greater than the "above" threshold and strictly less than the "below" threshold.
- R3: When the "above" threshold is greater than the "below" threshold (outside mode), an accepted result sets the flag if it is strictly greater than the "above" threshold or strictly less than the "below" threshold.
- R4: When the two thresholds are equal, the flag is set by any accepted result that differs from the shared threshold, and never by a result equal to it.
- R5: With `res_signed`=1, the result and both thresholds are compared as two's-complement numbers of width W. With `res_signed`=0, they are compared as unsigned numbers.
- R6: A cycle without an accepted result never sets the flag, whatever `res_data` holds.
- R7: The flag is set on the clock edge that accepts a qualifying result. It stays set until a `flag_clr` strobe, which clears it on that edge. If a qualifying result and `flag_clr` arrive in the same cycle, the flag ends set.
- R8: `win_irq` is high exactly when the flag is set and the interrupt enable is 1. The flag stays readable when the enable is 0.
- R9: A threshold write takes effect on its clock edge. A result accepted in the same cycle as the write is compared against the previous value.
- R10: `res_ready` goes high on the first edge after reset is released and stays high. The block never stalls the result stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Result accepted this cycle when high with res_valid |
| res_data | input | W | Conversion result code |
| res_signed | input | 1 | 1: two's-complement result, 0: unsigned result |
| gt_we | input | 1 | Write strobe for the "above" threshold |
| gt_wdata | input | W | New "above" threshold |
| lt_we | input | 1 | Write strobe for the "below" threshold |
| lt_wdata | input | W | New "below" threshold |
| ien_we | input | 1 | Write strobe for the interrupt enable |
| ien_wdata | input | 1 | New interrupt enable value |
| flag_clr | input | 1 | Clear strobe for the window flag |
| win_flag | output | 1 | Sticky window event flag |
| win_irq | output | 1 | Window interrupt request |

## Verification
The assertions check the following on every cycle:
- the flag's update rules: set on a qualifying accept, held without a clear, dropped by a lone clear, never raised without a set;
- that the thresholds hold between writes and load on the write edge;
- that the interrupt line never rises without the flag;
- that the stream never drops ready.

The assertions do not check whether a given result qualifies under a given pair of thresholds. Only the bench's sweep can show that. The sweep covers every threshold pair and every result of a 4-bit configuration in both number formats, and it includes the inside, outside and equal orderings. The bench's directed scenarios cover which threshold value a same-cycle write sees, and the set-over-clear precedence.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

  typedef enum logic {
    WIN_INSIDE  = 1'b0,
    WIN_OUTSIDE = 1'b1
  } win_mode_e;

  typedef struct packed {
    logic above_gt;
    logic below_lt;
    logic lt_over_gt;
  } cmp_flags_t;

endpackage

// File: rtl/wcmp_thresh_regs.sv
module wcmp_thresh_regs #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gt_we,
  input  logic [W-1:0] gt_wdata,
  input  logic         lt_we,
  input  logic [W-1:0] lt_wdata,
  input  logic         ien_we,
  input  logic         ien_wdata,
  output logic [W-1:0] gt_q,
  output logic [W-1:0] lt_q,
  output logic         ien_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gt_q  <= '0;
      lt_q  <= '0;
      ien_q <= 1'b0;
    end else begin
      if (gt_we)  gt_q  <= gt_wdata;
      if (lt_we)  lt_q  <= lt_wdata;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  // R9
  gt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gt_we |=> gt_q == $past(gt_wdata));

  // R9
  gt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gt_we |=> $stable(gt_q));

  // R9
  lt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_we |=> $stable(lt_q));

endmodule

// File: rtl/wcmp_window_eval.sv
module wcmp_window_eval
  import wcmp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] res_data,
  input  logic         res_signed,
  input  logic [W-1:0] gt_q,
  input  logic [W-1:0] lt_q,
  output logic         hit
);

  localparam int NOPS = 3;

  logic [W-1:0] raw    [NOPS];
  logic [W-1:0] biased [NOPS];

  assign raw[0] = res_data;
  assign raw[1] = gt_q;
  assign raw[2] = lt_q;

  // Two's-complement order maps onto unsigned order once the sign bit is inverted.
  for (genvar i = 0; i < NOPS; i++) begin : g_bias
    assign biased[i] = {raw[i][W-1] ^ res_signed, raw[i][W-2:0]};
  end

  cmp_flags_t cf;
  win_mode_e  mode;

  always_comb begin
    cf.above_gt   = biased[0] > biased[1];
    cf.below_lt   = biased[0] < biased[2];
    cf.lt_over_gt = biased[2] > biased[1];
    mode = cf.lt_over_gt ? WIN_INSIDE : WIN_OUTSIDE;
    if (mode == WIN_INSIDE) hit = cf.above_gt & cf.below_lt;
    else                    hit = cf.above_gt | cf.below_lt;
  end

endmodule

// File: rtl/wcmp_flag.sv
module wcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_q);

  // R6
  flag_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !set_i |=> !flag_q);

endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  output logic         res_ready,
  input  logic [W-1:0] res_data,
  input  logic         res_signed,
  input  logic         gt_we,
  input  logic [W-1:0] gt_wdata,
  input  logic         lt_we,
  input  logic [W-1:0] lt_wdata,
  input  logic         ien_we,
  input  logic         ien_wdata,
  input  logic         flag_clr,
  output logic         win_flag,
  output logic         win_irq
);

  logic [W-1:0] gt_q, lt_q;
  logic         ien_q;
  logic         hit;
  logic         accept;
  logic         rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign res_ready = rdy_q;
  assign accept    = res_valid & rdy_q;

  wcmp_thresh_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .gt_we     (gt_we),
    .gt_wdata  (gt_wdata),
    .lt_we     (lt_we),
    .lt_wdata  (lt_wdata),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .gt_q      (gt_q),
    .lt_q      (lt_q),
    .ien_q     (ien_q)
  );

  wcmp_window_eval #(.W(W)) u_eval (
    .res_data   (res_data),
    .res_signed (res_signed),
    .gt_q       (gt_q),
    .lt_q       (lt_q),
    .hit        (hit)
  );

  wcmp_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (accept & hit),
    .clr_i  (flag_clr),
    .flag_q (win_flag)
  );

  assign win_irq = win_flag & ien_q;

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq |-> win_flag);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> res_ready);

endmodule

// File: tb/adc_win_cmp_tb.sv
module adc_win_cmp_tb;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [W-1:0] res_data = '0;
  logic         res_signed = 1'b0;
  logic         gt_we = 1'b0;
  logic [W-1:0] gt_wdata = '0;
  logic         lt_we = 1'b0;
  logic [W-1:0] lt_wdata = '0;
  logic         ien_we = 1'b0;
  logic         ien_wdata = 1'b0;
  logic         flag_clr = 1'b0;
  logic         win_flag;
  logic         win_irq;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_win_cmp #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_signed(res_signed), .gt_we(gt_we), .gt_wdata(gt_wdata),
    .lt_we(lt_we), .lt_wdata(lt_wdata), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .flag_clr(flag_clr), .win_flag(win_flag), .win_irq(win_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    res_valid = 1'b0; gt_we = 1'b0; lt_we = 1'b0; ien_we = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_thr(input int g, input int l);
    gt_we = 1'b1; gt_wdata = W'(g); lt_we = 1'b1; lt_wdata = W'(l);
    tick();
  endtask

  task automatic clear();
    flag_clr = 1'b1;
    tick();
  endtask

  task automatic strobe(input int r, input bit s);
    res_valid = 1'b1; res_data = W'(r); res_signed = s;
    tick();
  endtask

  function automatic int to_val(input int v, input bit s);
    return (s && v >= N/2) ? v - N : v;
  endfunction

  function automatic bit exp_hit(input int g, input int l, input int r, input bit s);
    int gv, lv, rv;
    gv = to_val(g, s); lv = to_val(l, s); rv = to_val(r, s);
    if (lv > gv) return (rv > gv) && (rv < lv);
    return (rv > gv) || (rv < lv);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flag in reset", win_flag, 1'b0);
    chk("R1 irq in reset", win_irq, 1'b0);
    chk("R10 ready low in reset", res_ready, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R10 ready after reset", res_ready, 1'b1);

    // R1 thresholds reset to zero: equal window at 0
    strobe(0, 1'b0);
    chk("R1 zero thresholds, result 0", win_flag, 1'b0);
    strobe(5, 1'b0);
    chk("R1 zero thresholds, result 5", win_flag, 1'b1);
    chk("R1 enable reset to 0", win_irq, 1'b0);
    clear();
    chk("R7 clear drops flag", win_flag, 1'b0);

    // R6 unaccepted hitting data
    set_thr(2, 9);
    res_valid = 1'b0; res_data = W'(5); res_signed = 1'b0;
    tick();
    chk("R6 no valid no set", win_flag, 1'b0);

    // R7 sticky and precedence
    strobe(5, 1'b0);
    chk("R7 set on hit", win_flag, 1'b1);
    strobe(12, 1'b0);
    chk("R7 sticky over miss", win_flag, 1'b1);
    clear();
    chk("R7 cleared", win_flag, 1'b0);
    flag_clr = 1'b1;
    strobe(5, 1'b0);
    chk("R7 set wins over clear", win_flag, 1'b1);

    // R8 interrupt gating
    chk("R8 polled flag, irq disabled", win_irq, 1'b0);
    ien_we = 1'b1; ien_wdata = 1'b1;
    tick();
    chk("R8 irq when enabled", win_irq, 1'b1);
    clear();
    chk("R8 irq drops with flag", win_irq, 1'b0);
    ien_we = 1'b1; ien_wdata = 1'b0;
    tick();

    // R9 write in same cycle as result
    gt_we = 1'b1; gt_wdata = W'(6);
    strobe(5, 1'b0);
    chk("R9 same-cycle write uses old threshold", win_flag, 1'b1);
    clear();
    strobe(5, 1'b0);
    chk("R9 new threshold applies next", win_flag, 1'b0);

    // R2 R3 R4 R5 exhaustive sweep
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < N; g++) begin
        for (int l = 0; l < N; l++) begin
          set_thr(g, l);
          for (int r = 0; r < N; r++) begin
            string tag;
            clear();
            strobe(r, m[0]);
            if (g == l)     tag = "R4 equal thresholds";
            else if (m != 0) tag = "R5 signed window";
            else if (l > g) tag = "R2 inside window";
            else            tag = "R3 outside window";
            chk($sformatf("%s g=%0d l=%0d r=%0d", tag, g, l, r),
                win_flag, exp_hit(g, l, r, m[0]));
          end
        end
      end
    end

    chk("R10 ready held", res_ready, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule